// File: doc/BRIEF.md
# Masked keyword receive filter

This block sits on the receive side of a time-slotted serial link, directly after the deserializer. Each received word arrives with the number of the time slot (channel) it was carried in and a one-cycle valid strobe. The filter decides, word by word, whether to keep or drop it. The decision rests on a comparison with a programmable reference word, in which individual bit positions can be excluded from the comparison.

A polarity control selects which words are kept: those that equal the reference, or those that differ from it. A per-channel select vector limits the comparison to chosen slots; words on other slots always pass. The whole filter is active only when it is enabled and the link runs in slotted (multichannel) mode. Otherwise every word goes through unchanged.

Kept words leave one clock later, together with their channel number. A separate interrupt pulse reports each word on a compared channel that equals the reference, whether or not that word is kept. Dropped words leave no trace on the output and never hold up the input.

Top module: `kwf_filter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid and match_irq are 0.
- R2: A word equals the reference when, at every bit position where cfg_mask holds 0, in_word and cfg_key agree; a 1 in cfg_mask excludes that position from the comparison.
- R3: With cfg_keep_match=1, a word on a compared channel is passed only if it equals the reference.
- R4: With cfg_keep_match=0, a word on a compared channel is passed only if it differs from the reference.
- R5: Bit k of cfg_chan_sel set to 0 makes words on channel k skip the comparison, so they are always passed. A 1 makes that channel subject to comparison.
- R6: When cfg_filt_en=0 or cfg_multi=0, every valid word is passed and no channel counts as compared.
- R7: A word presented with in_valid in cycle n appears on out_word and out_chan with out_valid=1 in cycle n+1 if it is passed. out_valid is 0 in any cycle that follows a cycle without in_valid.
- R8: match_irq is high for exactly the cycle after a valid word that equals the reference on a compared channel while cfg_irq_en=1, independent of cfg_keep_match. It stays low otherwise, including on bypassed channels.
- R9: A dropped word gives out_valid=0 in its output cycle. Words may arrive on consecutive cycles, and each is judged on its own without stalling.
- R10: With reference 0x33333333, an all-zero mask, cfg_keep_match=1 and every channel compared, only words equal to 0x33333333 are passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received word strobe |
| in_word | input | W | Received word |
| in_chan | input | $clog2(NCH) | Channel (slot) number of the received word |
| cfg_key | input | W | Reference word |
| cfg_mask | input | W | 1 = bit excluded from comparison |
| cfg_chan_sel | input | NCH | 1 = channel is compared, 0 = channel bypasses |
| cfg_keep_match | input | 1 | 1 = keep equal words, 0 = keep differing words |
| cfg_filt_en | input | 1 | Filter enable |
| cfg_multi | input | 1 | Link is in multichannel mode |
| cfg_irq_en | input | 1 | Enables the match interrupt |
| out_valid | output | 1 | Kept word strobe |
| out_word | output | W | Kept word |
| out_chan | output | $clog2(NCH) | Channel of the kept word |
| match_irq | output | 1 | One-cycle match interrupt |

## Verification
The bench aims at words that differ from the reference only inside a masked field: a design that ignored the mask would drop them, and one that inverted it would pass mismatches in unmasked bits. It drives the same equal and differing words under both polarities and checks that the interrupt still fires when an equal word is dropped. A design that gated the interrupt with the keep decision would miss it there. Bypassed channels carrying the reference value are checked for a silent interrupt, and a stream of back-to-back alternating words is checked cycle by cycle. A design that held state between words, or stalled, would shift or lose outputs in that stream.

// File: rtl/kwf_pkg.sv
package kwf_pkg;

  // Outcome of judging one received word.
  typedef struct packed {
    logic keep;
    logic irq;
  } kwf_verdict_t;

  // Keep decision: a bypassed word is always kept; a compared word is kept
  // when its equality result agrees with the requested polarity.
  function automatic logic kwf_keep(input logic compared,
                                    input logic equal,
                                    input logic keep_equal);
    logic polarity_ok;
    polarity_ok = keep_equal ? equal : ~equal;
    return ~compared | polarity_ok;
  endfunction

  // Interrupt decision: an equal word on a compared channel, when enabled.
  function automatic logic kwf_irq(input logic compared,
                                   input logic equal,
                                   input logic irq_en);
    return compared & equal & irq_en;
  endfunction

endpackage

// File: rtl/kwf_match.sv
// Masked bitwise equality between a received word and the reference.
module kwf_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] key,
  input  logic [W-1:0] mask,
  output logic         equal
);

  logic [W-1:0] bit_diff;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // A masked position never reports a difference.
    assign bit_diff[b] = (word[b] ^ key[b]) & ~mask[b];
  end

  assign equal = ~|bit_diff;

endmodule

// File: rtl/kwf_chan_gate.sv
// Decides whether the current channel is subject to comparison.
module kwf_chan_gate #(
  parameter int NCH = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CW-1:0]  chan,
  input  logic [NCH-1:0] chan_sel,
  input  logic           filt_en,
  input  logic           multi,
  output logic           compared
);

  logic [NCH-1:0] hit;

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    assign hit[k] = (chan == CW'(k)) & chan_sel[k];
  end

  assign compared = filt_en & multi & (|hit);

endmodule

// File: rtl/kwf_decide.sv
// Turns the comparison result into keep and interrupt events.
module kwf_decide
  import kwf_pkg::*;
(
  input  logic in_valid,
  input  logic compared,
  input  logic equal,
  input  logic keep_equal,
  input  logic irq_en,
  output logic keep_evt,
  output logic irq_evt
);

  kwf_verdict_t verdict;

  always_comb begin
    verdict.keep = kwf_keep(compared, equal, keep_equal);
    verdict.irq  = kwf_irq(compared, equal, irq_en);
  end

  assign keep_evt = in_valid & verdict.keep;
  assign irq_evt  = in_valid & verdict.irq;

endmodule

// File: rtl/kwf_filter.sv
// Masked keyword receive filter: one register stage after the decision.
module kwf_filter #(
  parameter int W   = 32,
  parameter int NCH = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_word,
  input  logic [CW-1:0]  in_chan,
  input  logic [W-1:0]   cfg_key,
  input  logic [W-1:0]   cfg_mask,
  input  logic [NCH-1:0] cfg_chan_sel,
  input  logic           cfg_keep_match,
  input  logic           cfg_filt_en,
  input  logic           cfg_multi,
  input  logic           cfg_irq_en,
  output logic           out_valid,
  output logic [W-1:0]   out_word,
  output logic [CW-1:0]  out_chan,
  output logic           match_irq
);

  // Named internal events, visible to the bound checker.
  logic word_match;
  logic compare_active;
  logic keep_evt;
  logic irq_evt;

  kwf_match #(.W(W)) u_match (
    .word  (in_word),
    .key   (cfg_key),
    .mask  (cfg_mask),
    .equal (word_match)
  );

  kwf_chan_gate #(.NCH(NCH)) u_gate (
    .chan     (in_chan),
    .chan_sel (cfg_chan_sel),
    .filt_en  (cfg_filt_en),
    .multi    (cfg_multi),
    .compared (compare_active)
  );

  kwf_decide u_decide (
    .in_valid   (in_valid),
    .compared   (compare_active),
    .equal      (word_match),
    .keep_equal (cfg_keep_match),
    .irq_en     (cfg_irq_en),
    .keep_evt   (keep_evt),
    .irq_evt    (irq_evt)
  );

  // Control flops: reset to quiet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      match_irq <= 1'b0;
    end else begin
      out_valid <= keep_evt;
      match_irq <= irq_evt;
    end
  end

  // Data flops: load on every valid word, kept or not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word <= '0;
      out_chan <= '0;
    end else if (in_valid) begin
      out_word <= in_word;
      out_chan <= in_chan;
    end
  end

endmodule

// File: rtl/kwf_filter_chk.sv
// Property checker for kwf_filter, attached with bind below.
module kwf_filter_chk #(
  parameter int W  = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_word,
  input logic [CW-1:0] in_chan,
  input logic          cfg_keep_match,
  input logic          cfg_irq_en,
  input logic          cfg_filt_en,
  input logic          cfg_multi,
  input logic          compare_active,
  input logic          word_match,
  input logic          out_valid,
  input logic [W-1:0]  out_word,
  input logic [CW-1:0] out_chan,
  input logic          match_irq
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !match_irq));

  a_r3_drop_unequal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && compare_active && cfg_keep_match && !word_match) |=> !out_valid);

  a_r4_drop_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && compare_active && !cfg_keep_match && word_match) |=> !out_valid);

  a_r5_bypass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !compare_active) |=> out_valid);

  a_r6_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(cfg_filt_en && cfg_multi)) |=> out_valid);

  a_r7_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r7_data_carried: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word == $past(in_word) && out_chan == $past(in_chan)));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> $past(in_valid && cfg_irq_en && word_match && compare_active));

  a_r8_irq_bypass_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !compare_active) |=> !match_irq);

endmodule

bind kwf_filter kwf_filter_chk #(.W(W), .CW(CW)) u_kwf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_word        (in_word),
  .in_chan        (in_chan),
  .cfg_keep_match (cfg_keep_match),
  .cfg_irq_en     (cfg_irq_en),
  .cfg_filt_en    (cfg_filt_en),
  .cfg_multi      (cfg_multi),
  .compare_active (compare_active),
  .word_match     (word_match),
  .out_valid      (out_valid),
  .out_word       (out_word),
  .out_chan       (out_chan),
  .match_irq      (match_irq)
);

// File: tb/kwf_filter_bench.sv
module kwf_filter_bench;

  localparam int W   = 32;
  localparam int NCH = 16;
  localparam int CW  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [W-1:0]   in_word;
  logic [CW-1:0]  in_chan;
  logic [W-1:0]   cfg_key;
  logic [W-1:0]   cfg_mask;
  logic [NCH-1:0] cfg_chan_sel;
  logic           cfg_keep_match;
  logic           cfg_filt_en;
  logic           cfg_multi;
  logic           cfg_irq_en;
  logic           out_valid;
  logic [W-1:0]   out_word;
  logic [CW-1:0]  out_chan;
  logic           match_irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  kwf_filter #(.W(W), .NCH(NCH)) u_kwf_filter (
    .clk, .rst_n, .in_valid, .in_word, .in_chan,
    .cfg_key, .cfg_mask, .cfg_chan_sel, .cfg_keep_match,
    .cfg_filt_en, .cfg_multi, .cfg_irq_en,
    .out_valid, .out_word, .out_chan, .match_irq
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Bench model, written bit by bit from the requirements.
  function automatic bit model_compared(input logic [CW-1:0] ch);
    return cfg_filt_en && cfg_multi && cfg_chan_sel[ch];
  endfunction

  function automatic bit model_equal(input logic [W-1:0] w);
    bit eq = 1;
    for (int i = 0; i < W; i++)
      if (cfg_mask[i] == 1'b0 && w[i] != cfg_key[i]) eq = 0;
    return eq;
  endfunction

  // Drive one word at a falling edge, sample the result one clock later.
  task automatic send(input logic [W-1:0] w, input logic [CW-1:0] ch,
                      input string req);
    bit cmp, eq, exp_keep, exp_irq;
    cmp = model_compared(ch);
    eq  = model_equal(w);
    if (!cmp) exp_keep = 1;
    else if (cfg_keep_match) exp_keep = eq;
    else exp_keep = !eq;
    exp_irq = cmp && eq && cfg_irq_en;
    in_valid = 1'b1;
    in_word  = w;
    in_chan  = ch;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == exp_keep, req, "out_valid", W'(out_valid), W'(exp_keep));
    check(match_irq == exp_irq, req, "match_irq", W'(match_irq), W'(exp_irq));
    if (exp_keep) begin
      check(out_word == w, req, "out_word", out_word, w);
      check(out_chan == ch, req, "out_chan", W'(out_chan), W'(ch));
    end
  endtask

  task automatic idle(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, req, "idle out_valid", W'(out_valid), '0);
    check(match_irq == 1'b0, req, "idle match_irq", W'(match_irq), '0);
  endtask

  task automatic set_cfg(input logic [W-1:0] key, input logic [W-1:0] mask,
                         input logic [NCH-1:0] sel, input bit keep,
                         input bit en, input bit multi, input bit irq_en);
    cfg_key = key; cfg_mask = mask; cfg_chan_sel = sel;
    cfg_keep_match = keep; cfg_filt_en = en; cfg_multi = multi;
    cfg_irq_en = irq_en;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b1; in_word = 32'h33333333; in_chan = '0;
    set_cfg(32'h33333333, '0, '1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset out_valid", W'(out_valid), '0);
    check(match_irq == 1'b0, "R1", "reset match_irq", W'(match_irq), '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "post-reset out_valid", W'(out_valid), '0);
    check(match_irq == 1'b0, "R1", "post-reset match_irq", W'(match_irq), '0);
  endtask

  task automatic t_r10_example;
    set_cfg(32'h33333333, '0, '1, 1, 1, 1, 1);
    for (int i = 1; i <= 16; i++)
      send(W'(i % 16) * 32'h11111111, CW'((i - 1) % 8), "R10");
    idle("R7");
  endtask

  task automatic t_r2_mask;
    set_cfg(32'h33333333, 32'h000000FF, '1, 1, 1, 1, 1);
    send(32'h333333AB, 4'd2, "R2");   // differs only in masked byte: kept
    send(32'h343333AB, 4'd2, "R2");   // differs in unmasked bit: dropped
    set_cfg(32'h33333333, 32'hFFFFFFFF, '1, 1, 1, 1, 1);
    send(32'hDEADBEEF, 4'd5, "R2");   // fully masked: always equal
    idle("R2");
  endtask

  task automatic t_r3_r4_polarity;
    set_cfg(32'hA5A5_0F0F, '0, '1, 1, 1, 1, 1);
    send(32'hA5A5_0F0F, 4'd1, "R3");
    send(32'hA5A5_0F0E, 4'd1, "R3");
    cfg_keep_match = 0;
    send(32'hA5A5_0F0F, 4'd1, "R4");  // equal word dropped, irq still fires
    send(32'hA5A5_0F0E, 4'd1, "R4");
    idle("R4");
  endtask

  task automatic t_r5_bypass;
    set_cfg(32'h1234_5678, '0, 16'h00FF, 1, 1, 1, 1);
    send(32'h0000_0000, 4'd9, "R5");  // unequal on bypassed channel: kept
    send(32'h1234_5678, 4'd12, "R5"); // equal on bypassed: kept, no irq
    send(32'h0000_0000, 4'd7, "R5");  // compared channel: dropped
    idle("R5");
  endtask

  task automatic t_r6_disable;
    set_cfg(32'h1234_5678, '0, '1, 1, 0, 1, 1);
    send(32'h0BAD_F00D, 4'd3, "R6");
    send(32'h1234_5678, 4'd3, "R6");
    set_cfg(32'h1234_5678, '0, '1, 1, 1, 0, 1);
    send(32'h0BAD_F00D, 4'd4, "R6");
    idle("R6");
  endtask

  task automatic t_r8_irq_enable;
    set_cfg(32'h5555_AAAA, '0, '1, 1, 1, 1, 0);
    send(32'h5555_AAAA, 4'd0, "R8");
    cfg_irq_en = 1;
    send(32'h5555_AAAA, 4'd15, "R8");
    send(32'h5555_AAAA, 4'd15, "R8");
    idle("R8");
  endtask

  task automatic t_r9_stream;
    set_cfg(32'hCAFE_0001, 32'h0000_00F0, '1, 1, 1, 1, 1);
    for (int i = 0; i < 12; i++)
      send((i % 2 == 0) ? 32'hCAFE_0001 | W'((i & 15) << 4) : 32'hCAFE_1001,
           CW'(i), "R9");
    idle("R9");
  endtask

  initial begin
    t_reset;
    t_r10_example;
    t_r2_mask;
    t_r3_r4_polarity;
    t_r5_bypass;
    t_r6_disable;
    t_r8_irq_enable;
    t_r9_stream;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule